// File: doc/BRIEF.md
# Serial Frame Transmitter with Programmable Bit-Rate Divider

This block turns three configuration words into a serial character format and a bit-rate tick, and shifts characters out on a single line in that format. A mode word selects the data length, the parity type, the number of stop bits and an optional divide-by-8 prescale of the input clock. A clock divisor and a bit divisor set the bit period together: the period is the prescale factor times the clock divisor times (bit divisor + 1) input clocks. The block also reports the length of one character in bit periods, so that neighbouring logic can size receive timeouts.

Characters enter through a valid/ready handshake, one byte per transfer. The transmitter is a state machine with five states. `ST_IDLE` drives the line high and holds ready high. An accepted byte moves it to `ST_START`. One bit period later it moves to `ST_DATA`, which lasts one period per configured data bit. It then goes to `ST_PARITY` when a parity type is selected, or directly to `ST_STOP` otherwise. From `ST_PARITY` it moves to `ST_STOP` after one period. `ST_STOP` returns to `ST_IDLE` after the last stop bit. Each transition except the one out of `ST_IDLE` happens on a bit tick. The divider restarts when a byte is accepted, so every bit of the character lasts exactly one bit period.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line is high, ready is high, the mode word is 0 (8 data bits, even parity, two stop bits, so 12 bit periods per character), the clock divisor is 15 and the bit divisor is 0. The reset bit period is therefore 15 clocks.
- R2: `bit_tick` is a one-cycle pulse. Its period in clocks is P × CD × (BD + 1), where CD is the clock divisor and BD is the bit divisor. P is 8 when mode bit 0 is 1 and 1 otherwise.
- R3: A clock divisor of 0 stops `bit_tick` completely, and no division by zero takes place.
- R4: Data length comes from mode bits [2:1]: 2'b11 selects 6 bits, 2'b10 selects 7 bits, and 2'b00 or 2'b01 selects 8 bits.
- R5: Parity comes from mode bits [5:3]: 3'd0 selects even parity, 3'd1 selects odd parity, and any other value sends no parity bit. The parity bit is computed over the configured data bits only. With even parity the count of ones in the data bits plus the parity bit is even.
- R6: Stop bits come from mode bits [7:6]: 2'b11 selects one stop bit and any other value selects two. Stop bits are high.
- R7: `char_bits` equals 1 + data length + (1 if parity is used) + stop bits, computed from the current mode word.
- R8: A character is sent as one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits. Each bit lasts one bit period counted from the accepting clock edge. Ready stays low from acceptance until the frame ends.
- R9: Data length, parity and stop-bit settings are captured when a byte is accepted. A mode write during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_in | input | 8 | Mode word value |
| cd_wr | input | 1 | Write strobe for the clock divisor |
| cd_in | input | CD_W | Clock divisor value |
| bd_wr | input | 1 | Write strobe for the bit divisor |
| bd_in | input | BD_W | Bit divisor value |
| in_valid | input | 1 | Byte offered for transmission |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Transmitter idle and able to accept a byte |
| tx_line | output | 1 | Serial output, high when idle |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| char_bits | output | 4 | Bit periods per character for the current mode |

## Verification
The assertions check four properties on every cycle:
- a zero clock divisor never produces a tick;
- `char_bits` stays within 8 to 12;
- the line is high whenever ready is high;
- an acceptance is followed by a low start bit with ready dropped, and the line changes during a frame only on a tick.

Other behaviour can only be shown by the bench's scenarios, which compare every bit of whole frames with frames built from the requirements:
- the exact tick period for each prescale and divisor combination;
- the data-length, parity and stop decodes;
- LSB-first order and parity restricted to the configured data bits;
- format capture across a mid-frame mode write.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    // Field positions inside the mode word
    localparam int MODE_PRE_BIT = 0;
    localparam int MODE_LEN_LSB = 1;
    localparam int MODE_PAR_LSB = 3;
    localparam int MODE_STP_LSB = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_mode(input logic [7:0] m);
        frame_fmt_t f;
        logic [1:0] len_f;
        logic [2:0] par_f;
        logic [1:0] stp_f;
        len_f = m[MODE_LEN_LSB +: 2];
        par_f = m[MODE_PAR_LSB +: 3];
        stp_f = m[MODE_STP_LSB +: 2];
        case (len_f)
            2'b11:   f.data_bits = 4'd6;
            2'b10:   f.data_bits = 4'd7;
            default: f.data_bits = 4'd8;
        endcase
        f.par_en   = (par_f == 3'd0) || (par_f == 3'd1);
        f.par_odd  = (par_f == 3'd1);
        f.two_stop = (stp_f != 2'b11);
        return f;
    endfunction

    // XOR over the lowest n bits of d
    function automatic logic low_bits_xor(input logic [7:0] d, input logic [3:0] n);
        logic p;
        p = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(n)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/uftx_frame_decode.sv
module uftx_frame_decode
    import uftx_pkg::*;
(
    input  logic [7:0]  mode,
    output frame_fmt_t  fmt,
    output logic        pre_en,
    output logic [3:0]  char_bits
);
    always_comb begin
        fmt       = decode_mode(mode);
        pre_en    = mode[MODE_PRE_BIT];
        char_bits = 4'd1 + fmt.data_bits + {3'd0, fmt.par_en}
                    + (fmt.two_stop ? 4'd2 : 4'd1);
    end
endmodule

// File: rtl/uftx_baud_div.sv
module uftx_baud_div #(
    parameter int CD_W    = 16,
    parameter int BD_W    = 8,
    parameter int PRE_DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            pre_en,
    input  logic [CD_W-1:0] cd,
    input  logic [BD_W-1:0] bdiv,
    output logic            bit_tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [CD_W-1:0]  cd_cnt;
    logic [BD_W-1:0]  bd_cnt;
    logic             pre_tick, samp_tick, cd_zero, cd_last, bd_last;

    always_comb begin
        cd_zero   = (cd == '0);
        pre_tick  = pre_en ? (pre_cnt == PRE_LAST) : 1'b1;
        cd_last   = (cd_cnt >= cd - 1'b1);
        samp_tick = pre_tick && !cd_zero && cd_last;
        bd_last   = (bd_cnt >= bdiv);
        bit_tick  = samp_tick && bd_last;
    end

    // Stage 0: optional prescale
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !pre_en) pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST)     pre_cnt <= '0;
        else                              pre_cnt <= pre_cnt + 1'b1;
    end

    // Stage 1: clock divisor
    always_ff @(posedge clk) begin
        if (!rst_n || restart || cd_zero) cd_cnt <= '0;
        else if (pre_tick)                cd_cnt <= cd_last ? '0 : cd_cnt + 1'b1;
    end

    // Stage 2: bit divisor (counts bdiv+1 samples)
    always_ff @(posedge clk) begin
        if (!rst_n || restart || cd_zero) bd_cnt <= '0;
        else if (samp_tick)               bd_cnt <= bd_last ? '0 : bd_cnt + 1'b1;
    end

    // R2: with a divisor above one, ticks never come back to back
    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && (cd > 1) && $stable(cd) && !restart) |=> !bit_tick);
endmodule

// File: rtl/uftx_tx_fsm.sv
module uftx_tx_fsm
    import uftx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  frame_fmt_t  fmt,
    output logic        in_ready,
    output logic        accept,
    output logic        tx_line
);
    tx_state_e  state, state_nx;
    logic [7:0] shreg;
    logic [3:0] bits_left;
    logic       par_bit, par_en_q, stop_more;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_START;
            ST_START:  if (bit_tick) state_nx = ST_DATA;
            ST_DATA:   if (bit_tick && bits_left == 4'd1)
                           state_nx = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_tick) state_nx = ST_STOP;
            ST_STOP:   if (bit_tick && !stop_more) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Character datapath, format captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            par_bit   <= 1'b0;
            par_en_q  <= 1'b0;
            stop_more <= 1'b0;
        end else if (accept) begin
            shreg     <= in_data;
            bits_left <= fmt.data_bits;
            par_bit   <= low_bits_xor(in_data, fmt.data_bits) ^ fmt.par_odd;
            par_en_q  <= fmt.par_en;
            stop_more <= fmt.two_stop;
        end else if (bit_tick) begin
            if (state == ST_DATA) begin
                shreg     <= {1'b0, shreg[7:1]};
                bits_left <= bits_left - 1'b1;
            end
            if (state == ST_STOP) stop_more <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        in_ready = (state == ST_IDLE);
        accept   = in_ready && in_valid;
        unique case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg[0];
            ST_PARITY: tx_line = par_bit;
            default:   tx_line = 1'b1;
        endcase
    end

    // R8: acceptance starts a low start bit and drops ready
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!tx_line && !in_ready));
    // R8: inside a frame the line only moves on a tick
    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !bit_tick) |=> $stable(tx_line));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int               CD_W       = 16,
    parameter int               BD_W       = 8,
    parameter int               PRE_DIV    = 8,
    parameter logic [7:0]       MODE_RESET = 8'h00,
    parameter logic [CD_W-1:0]  CD_RESET   = CD_W'(15),
    parameter logic [BD_W-1:0]  BD_RESET   = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic [7:0]      mode_in,
    input  logic            cd_wr,
    input  logic [CD_W-1:0] cd_in,
    input  logic            bd_wr,
    input  logic [BD_W-1:0] bd_in,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic            tx_line,
    output logic            bit_tick,
    output logic [3:0]      char_bits
);
    import uftx_pkg::*;

    logic [7:0]      mode_q;
    logic [CD_W-1:0] cd_q;
    logic [BD_W-1:0] bd_q;
    frame_fmt_t      fmt;
    logic            pre_en, accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            cd_q   <= CD_RESET;
            bd_q   <= BD_RESET;
        end else begin
            if (mode_wr) mode_q <= mode_in;
            if (cd_wr)   cd_q   <= cd_in;
            if (bd_wr)   bd_q   <= bd_in;
        end
    end

    uftx_frame_decode i_decode (
        .mode      (mode_q),
        .fmt       (fmt),
        .pre_en    (pre_en),
        .char_bits (char_bits)
    );

    uftx_baud_div #(.CD_W(CD_W), .BD_W(BD_W), .PRE_DIV(PRE_DIV)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .pre_en   (pre_en),
        .cd       (cd_q),
        .bdiv     (bd_q),
        .bit_tick (bit_tick)
    );

    uftx_tx_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .fmt      (fmt),
        .in_ready (in_ready),
        .accept   (accept),
        .tx_line  (tx_line)
    );

    // R3: a zero clock divisor never yields a tick
    p_no_tick_cd0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q == '0) |-> !bit_tick);
    // R7: character length stays within the decodable range
    p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_bits >= 4'd8) && (char_bits <= 4'd12));
    // R8: an idle transmitter holds the line high
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);
endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
    localparam int HALF = 10;  // 20 ns period, 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0, cd_wr = 1'b0, bd_wr = 1'b0;
    logic [7:0]  mode_in = '0;
    logic [15:0] cd_in = '0;
    logic [7:0]  bd_in = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, tx_line, bit_tick;
    logic [3:0]  char_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_in(mode_in),
        .cd_wr(cd_wr), .cd_in(cd_in),
        .bd_wr(bd_wr), .bd_in(bd_in),
        .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx_line(tx_line),
        .bit_tick(bit_tick), .char_bits(char_bits)
    );

    // Vector: mode, clock divisor, bit divisor, data byte
    typedef struct packed {
        logic [7:0]  mode;
        logic [15:0] cd;
        logic [7:0]  bd;
        logic [7:0]  data;
    } vec_t;
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 16'd3, 8'd0, 8'hA5},   // 8 bits, even, two stops
        '{8'h08, 16'd2, 8'd1, 8'h3C},   // 8 bits, odd, two stops
        '{8'hC6, 16'd2, 8'd0, 8'h7F},   // 6 bits, even, one stop
        '{8'hCC, 16'd3, 8'd1, 8'h81},   // 7 bits, odd, one stop
        '{8'hE1, 16'd2, 8'd0, 8'h5A},   // 8 bits, none, one stop, prescale
        '{8'h7E, 16'd1, 8'd2, 8'hC3}    // 6 bits, none, two stops
    };

    function automatic int ref_len(input logic [7:0] m);
        int dl;
        dl = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
        return dl;
    endfunction

    function automatic int ref_frame_len(input logic [7:0] m);
        int par;
        par = (m[5:3] <= 3'd1) ? 1 : 0;
        return 1 + ref_len(m) + par + ((m[7:6] == 2'b11) ? 1 : 2);
    endfunction

    function automatic logic ref_bit(input logic [7:0] m, input logic [7:0] d, input int i);
        int dl;
        logic ones;
        dl = ref_len(m);
        if (i == 0) return 1'b0;
        if (i <= dl) return d[i-1];
        if (i == dl + 1 && m[5:3] <= 3'd1) begin
            ones = 1'b0;
            for (int j = 0; j < dl; j++) ones = ones ^ d[j];
            return (m[5:3] == 3'd1) ? ~ones : ones;
        end
        return 1'b1;
    endfunction

    function automatic int ref_period(input logic [7:0] m, input int cd, input int bd);
        return (m[0] ? 8 : 1) * cd * (bd + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] m, input logic [15:0] cd, input logic [7:0] bd);
        @(negedge clk);
        mode_in = m; cd_in = cd; bd_in = bd;
        mode_wr = 1'b1; cd_wr = 1'b1; bd_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; cd_wr = 1'b0; bd_wr = 1'b0;
    endtask

    // Clocks between two consecutive ticks, sampled at negedges
    task automatic measure_period(output int p);
        int guard;
        guard = 0;
        while (!bit_tick && guard < 1000) begin @(negedge clk); guard++; end
        p = 0;
        @(negedge clk); p = 1;
        while (!bit_tick && p < 1000) begin @(negedge clk); p++; end
    endtask

    task automatic run_frame(input logic [7:0] m, input logic [7:0] d, input int t,
                             input bit mid, input logic [7:0] mid_m, input string req);
        int n, guard;
        n = ref_frame_len(m);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
        repeat (t / 2) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            check(tx_line == ref_bit(m, d, i), req, int'(tx_line), int'(ref_bit(m, d, i)),
                  $sformatf("mode %02h data %02h bit %0d", m, d, i));
            if (i == 1) check(!in_ready, "R8", int'(in_ready), 0, "ready during frame");
            if (mid && i == 2) begin
                mode_in = mid_m; mode_wr = 1'b1;
                @(negedge clk);
                mode_wr = 1'b0;
                repeat (t - 1) @(negedge clk);
            end else begin
                repeat (t) @(negedge clk);
            end
        end
        guard = 0;
        while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
        check(in_ready && tx_line, "R8", int'({in_ready, tx_line}), 3, "idle after frame");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int p, ticks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(tx_line == 1'b1, "R1", int'(tx_line), 1, "line after reset");
        check(in_ready == 1'b1, "R1", int'(in_ready), 1, "ready after reset");
        check(char_bits == 4'd12, "R1", int'(char_bits), 12, "char_bits after reset");
        measure_period(p);
        check(p == 15, "R1", p, 15, "reset bit period");

        // R2: prescaled period
        write_cfg(8'h01, 16'd3, 8'd2);
        measure_period(p);
        check(p == 72, "R2", p, 72, "prescaled period");
        write_cfg(8'h00, 16'd5, 8'd3);
        measure_period(p);
        check(p == 20, "R2", p, 20, "two-stage period");

        // Vector table: R4, R5, R6, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(VECS[v].mode, VECS[v].cd, VECS[v].bd);
            check(int'(char_bits) == ref_frame_len(VECS[v].mode), "R7",
                  int'(char_bits), ref_frame_len(VECS[v].mode), "char_bits");
            run_frame(VECS[v].mode, VECS[v].data,
                      ref_period(VECS[v].mode, int'(VECS[v].cd), int'(VECS[v].bd)),
                      1'b0, 8'h00, "R4/R5/R6 frame");
        end

        // R9: mode rewrite mid-frame leaves the frame intact
        write_cfg(8'hE0, 16'd4, 8'd0);
        run_frame(8'hE0, 8'h96, 4, 1'b1, 8'hE6, "R9");
        check(char_bits == 4'd8, "R7", int'(char_bits), 8, "char_bits after rewrite");

        // R3: zero clock divisor stops ticks
        write_cfg(8'h00, 16'd0, 8'd0);
        ticks = 0;
        repeat (200) begin @(negedge clk); if (bit_tick) ticks++; end
        check(ticks == 0, "R3", ticks, 0, "ticks with zero divisor");
        check(tx_line == 1'b1, "R3", int'(tx_line), 1, "line with zero divisor");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule